// File: doc/BRIEF.md
# Converter Serial Command Port Controller

This block is the device-side digital controller behind the serial port of a four-input data converter. A host sends one 8-bit command byte, most significant bit first, one bit per serial clock strobe. The byte tells the controller whether to run one conversion, run conversions continuously, or run a calibration. It also picks which of eight stored setups to use. Each setup names the physical input channel. Setups are held two per register in four setup registers, which a parallel preload port fills.

A conversion is modelled rather than performed. A down-counter sets its latency, and the result is taken from a test data input. When a result is ready the controller pulls the serial output low. The host then clocks out a 40-clock frame: 8 flag clocks followed by 32 data bits.

In continuous mode, the bits the host drives during the flag clocks decide the next step. All ones ends the mode. Anything else keeps it running. A result the host does not read is overwritten by the next one. Calibration commands only keep the port busy for a set time and then return it to command mode.

Top module: `adc_cmd_port`

## Requirements
- R1: While reset is held, and after it, `sdo` is 1 and `conv_active` is 0 until a valid command arrives.
- R2: A command byte is sampled from `sdi` on 8 `sclk_pulse` strobes, most significant bit first. Bit 7 must be 1 or the byte is ignored. Bit 6 set means continuous mode. Bits 5:3 are the setup pointer. Bits 2:0 are the operation code, where 000 means conversion.
- R3: Pointer value p (0..7) selects setup p+1. Setup register k (0..3) holds setup 2k+1 in bits 1:0 and setup 2k+2 in bits 3:2. A field value f names physical channel f+1, which appears on `sel_chan` once the command is accepted.
- R4: After an accepted conversion command, `conv_active` is 1 and `sdo` goes low exactly FIRST_LAT clock cycles after the clock edge that took the eighth command bit.
- R5: A result frame is 40 strobes long. Before strobe i (i = 0..39), `sdo` carries bit i of the frame. Bits 0..7 are zeros. Bits 8..31 are the 24-bit result, most significant bit first. Bits 32..34 are the setup pointer, most significant bit first. Bits 35..39 are zero.
- R6: After the frame of a single conversion, the port is in command mode: `sdo` stays 1 and `conv_active` stays 0.
- R7: In continuous mode the first result takes FIRST_LAT cycles. After a frame that keeps the mode, the next result is flagged STEADY_LAT cycles after the edge of the fortieth strobe.
- R8: In continuous mode, `sdi` all ones on the 8 flag strobes ends the mode after the frame. Any other pattern keeps it running.
- R9: In continuous mode, a flagged result left unread is replaced by a new sample of `conv_data` every STEADY_LAT cycles. `sdo` stays low meanwhile.
- R10: A command with a nonzero operation code keeps `conv_active` 0 and `sdo` 1 for CAL_LAT cycles, then returns to command mode.
- R11: Strobes that arrive while a conversion is running are discarded and do not change the pointer or the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk_pulse | input | 1 | One-cycle strobe for each serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out and ready flag (low = ready) |
| pre_we | input | 1 | Setup register preload write enable |
| pre_idx | input | 2 | Setup register index |
| pre_data | input | 4 | Setup register contents (two 2-bit channel fields) |
| conv_data | input | 24 | Modelled conversion result |
| conv_active | output | 1 | A conversion is in progress |
| sel_chan | output | 3 | Physical channel (1..4) of the selected setup |

## Verification
The bench builds the block with FIRST_LAT 37, STEADY_LAT 23 and CAL_LAT 50. These short latencies let one run cover every mode, while FIRST_LAT still stays longer than STEADY_LAT. FIRST_LAT is also long enough that a whole second command byte fits inside a conversion, which exercises R11. It is short enough to measure every latency to the exact cycle. The gap between STEADY_LAT and twice that value gives a clean window in which an unread result has been replaced exactly once.

// File: rtl/adc_cmd_port.sv
module adc_cmd_port #(
  parameter int NCH        = 4,
  parameter int RES_W      = 24,
  parameter int FIRST_LAT  = 2966,
  parameter int STEADY_LAT = 2560,
  parameter int CAL_LAT    = 3000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sclk_pulse,
  input  logic                     sdi,
  output logic                     sdo,
  input  logic                     pre_we,
  input  logic [1:0]               pre_idx,
  input  logic [2*$clog2(NCH)-1:0] pre_data,
  input  logic [RES_W-1:0]         conv_data,
  output logic                     conv_active,
  output logic [$clog2(NCH):0]     sel_chan
);
  localparam int CH_W   = $clog2(NCH);
  localparam int FLAGS  = 8;
  localparam int WORD_W = 32;
  localparam int FRAME  = FLAGS + WORD_W;
  localparam int MAXL   = (FIRST_LAT > STEADY_LAT) ?
                          ((FIRST_LAT > CAL_LAT) ? FIRST_LAT : CAL_LAT) :
                          ((STEADY_LAT > CAL_LAT) ? STEADY_LAT : CAL_LAT);
  localparam int CW     = $clog2(MAXL + 1);

  typedef enum logic [2:0] {S_CMD, S_BUSY, S_RDY, S_READ, S_CAL} st_t;

  st_t               st;
  logic [6:0]        sh;
  logic [2:0]        bcnt;
  logic [2:0]        ptr;
  logic              cont;
  logic [CW-1:0]     cnt;
  logic [RES_W-1:0]  res;
  logic [5:0]        idx;
  logic [7:0]        flg;
  logic [2*CH_W-1:0] csr [4];

  logic [2:0]        code;
  logic [WORD_W-1:0] word;
  logic [5:0]        widx;
  logic [CH_W-1:0]   fld;

  assign code = {sh[1:0], sdi};
  assign word = {res, ptr, {(WORD_W-RES_W-3){1'b0}}};
  assign widx = 6'(FRAME - 1) - idx;
  assign fld  = csr[ptr[2:1]][ptr[0]*CH_W +: CH_W];

  assign sel_chan    = {1'b0, fld} + 1'b1;
  assign conv_active = (st == S_BUSY) || (st == S_RDY && cont);
  assign sdo = (st == S_RDY)  ? 1'b0 :
               (st == S_READ) ? ((idx < 6'(FLAGS)) ? 1'b0 : word[widx[4:0]]) :
               1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_CMD;
      sh   <= '0;
      bcnt <= '0;
      ptr  <= '0;
      cont <= 1'b0;
      cnt  <= '0;
      res  <= '0;
      idx  <= '0;
      flg  <= '0;
      for (int k = 0; k < 4; k++) csr[k] <= '0;
    end else begin
      if (pre_we) csr[pre_idx] <= pre_data;
      case (st)
        S_CMD: if (sclk_pulse) begin
          sh   <= {sh[5:0], sdi};
          bcnt <= bcnt + 3'd1;
          if (bcnt == 3'd7 && sh[6]) begin
            ptr  <= sh[4:2];
            cont <= sh[5];
            if (code == 3'd0) begin
              st  <= S_BUSY;
              cnt <= CW'(FIRST_LAT - 1);
            end else begin
              st  <= S_CAL;
              cnt <= CW'(CAL_LAT - 1);
            end
          end
        end
        S_BUSY: if (cnt == '0) begin
          res <= conv_data;
          st  <= S_RDY;
          idx <= '0;
          cnt <= CW'(STEADY_LAT - 1);
        end else cnt <= cnt - 1'b1;
        S_RDY: if (sclk_pulse) begin
          st  <= S_READ;
          idx <= 6'd1;
          flg <= {flg[6:0], sdi};
        end else if (cont) begin
          if (cnt == '0) begin
            res <= conv_data;
            cnt <= CW'(STEADY_LAT - 1);
          end else cnt <= cnt - 1'b1;
        end
        S_READ: if (sclk_pulse) begin
          idx <= idx + 6'd1;
          if (idx < 6'(FLAGS)) flg <= {flg[6:0], sdi};
          if (idx == 6'(FRAME - 1)) begin
            if (!cont) st <= S_CMD;
            else if (flg == 8'hFF) begin
              st   <= S_CMD;
              cont <= 1'b0;
            end else begin
              st  <= S_BUSY;
              cnt <= CW'(STEADY_LAT - 1);
            end
          end
        end
        S_CAL: if (cnt == '0) st <= S_CMD;
               else cnt <= cnt - 1'b1;
        default: st <= S_CMD;
      endcase
    end
  end

  // R2: a byte without the command flag leaves the port in command mode
  a_r2_ignore_noflag: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CMD && sclk_pulse && bcnt == 3'd7 && !sh[6]) |=> (st == S_CMD));

  // R6: a single conversion returns to command mode after its frame
  a_r6_single_return: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_READ && sclk_pulse && idx == 6'(FRAME - 1) && !cont) |=> (st == S_CMD && sdo));

  // R7: a frame that keeps continuous mode restarts with the steady latency
  a_r7_steady_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_READ && sclk_pulse && idx == 6'(FRAME - 1) && cont && flg != 8'hFF)
    |=> (st == S_BUSY && cnt == CW'(STEADY_LAT - 1)));

  // R8: all-ones flags end continuous mode
  a_r8_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_READ && sclk_pulse && idx == 6'(FRAME - 1) && cont && flg == 8'hFF)
    |=> (st == S_CMD && !cont && !conv_active));

  // R10: calibration never flags a result
  a_r10_cal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CAL) |-> (sdo && !conv_active));

  // R11: strobes during a conversion leave pointer and mode alone
  a_r11_busy_discard: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BUSY && sclk_pulse) |=> ($stable(ptr) && $stable(cont)));
endmodule

// File: tb/test_adc_cmd_port.sv
module test_adc_cmd_port;
  localparam int CLK_P  = 10;
  localparam int FIRST  = 37;
  localparam int STEADY = 23;
  localparam int CAL    = 50;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        sclk_pulse = 0;
  logic        sdi = 0;
  logic        sdo;
  logic        pre_we = 0;
  logic [1:0]  pre_idx = 0;
  logic [3:0]  pre_data = 0;
  logic [23:0] conv_data = 0;
  logic        conv_active;
  logic [2:0]  sel_chan;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #(CLK_P/2) clk = ~clk;

  adc_cmd_port #(.NCH(4), .RES_W(24), .FIRST_LAT(FIRST), .STEADY_LAT(STEADY),
                 .CAL_LAT(CAL)) i_adc_cmd_port (
    .clk(clk), .rst_n(rst_n), .sclk_pulse(sclk_pulse), .sdi(sdi), .sdo(sdo),
    .pre_we(pre_we), .pre_idx(pre_idx), .pre_data(pre_data),
    .conv_data(conv_data), .conv_active(conv_active), .sel_chan(sel_chan));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      sdi = b[7-i];
      sclk_pulse = 1;
      @(negedge clk);
      sclk_pulse = 0;
      if (i < 7) @(negedge clk);
    end
    sdi = 0;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (sdo === 1'b1 && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic read_frame(input logic [7:0] fl, output logic [31:0] w, output logic [7:0] fb);
    w = '0;
    fb = '0;
    for (int i = 0; i < 40; i++) begin
      if (i < 8) fb[7-i] = sdo;
      else w[39-i] = sdo;
      sdi = (i < 8) ? fl[7-i] : 1'b0;
      sclk_pulse = 1;
      @(negedge clk);
      sclk_pulse = 0;
      if (i < 39) @(negedge clk);
    end
    sdi = 0;
  endtask

  task automatic quiet(input int cyc, input string req);
    bit ok = 1;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (sdo !== 1'b1 || conv_active !== 1'b0) ok = 0;
    end
    chk(ok, req, {sdo, conv_active}, 2'b10);
  endtask

  function automatic logic [31:0] frame_word(input logic [23:0] d, input logic [2:0] p);
    return {d, p, 5'b0};
  endfunction

  initial begin
    int chan[8] = '{4, 1, 1, 2, 4, 3, 4, 4};
    int n;
    logic [31:0] w;
    logic [7:0]  fb;

    repeat (3) @(negedge clk);
    chk(sdo === 1'b1 && conv_active === 1'b0, "R1 reset", {sdo, conv_active}, 2'b10);
    rst_n = 1;
    @(negedge clk);
    chk(sdo === 1'b1 && conv_active === 1'b0, "R1 after reset", {sdo, conv_active}, 2'b10);

    for (int k = 0; k < 4; k++) begin
      pre_we = 1;
      pre_idx = 2'(k);
      pre_data = {2'(chan[2*k+1] - 1), 2'(chan[2*k] - 1)};
      @(negedge clk);
    end
    pre_we = 0;

    send_bits(8'h00);
    quiet(30, "R2 byte without flag ignored");

    conv_data = 24'hA5C31E;
    send_bits(8'h80);
    chk(conv_active === 1'b1, "R4 active", conv_active, 1);
    chk(sel_chan == 3'd4, "R3 setup1", sel_chan, 4);
    wait_ready(n);
    chk(n == FIRST, "R4 latency", n, FIRST);
    read_frame(8'h00, w, fb);
    chk(fb == 8'h00, "R5 flag clocks", fb, 0);
    chk(w == frame_word(24'hA5C31E, 3'd0), "R5 frame", w, frame_word(24'hA5C31E, 3'd0));
    quiet(40, "R6 single returns to command mode");

    conv_data = 24'h123456;
    send_bits(8'hD0);
    chk(sel_chan == 3'd1, "R3 setup3", sel_chan, 1);
    wait_ready(n);
    chk(n == FIRST, "R7 first latency", n, FIRST);
    read_frame(8'h00, w, fb);
    chk(w == frame_word(24'h123456, 3'd2), "R7 first frame", w, frame_word(24'h123456, 3'd2));
    conv_data = 24'hFEDCBA;
    wait_ready(n);
    chk(n == STEADY, "R7 steady latency", n, STEADY);
    conv_data = 24'h0F0F0F;
    repeat (STEADY + 3) @(negedge clk);
    chk(sdo === 1'b0, "R9 stays flagged", sdo, 0);
    read_frame(8'hFF, w, fb);
    chk(w == frame_word(24'h0F0F0F, 3'd2), "R9 replaced result", w, frame_word(24'h0F0F0F, 3'd2));
    quiet(60, "R8 all ones exits");

    send_bits(8'h99);
    chk(sel_chan == 3'd2, "R3 setup4", sel_chan, 2);
    quiet(CAL + 10, "R10 calibration quiet");
    conv_data = 24'h00FF00;
    send_bits(8'hA8);
    chk(sel_chan == 3'd3, "R3 setup6", sel_chan, 3);
    wait_ready(n);
    chk(n == FIRST, "R10 back in command mode", n, FIRST);
    read_frame(8'h00, w, fb);
    chk(w == frame_word(24'h00FF00, 3'd5), "R5 frame setup6", w, frame_word(24'h00FF00, 3'd5));
    quiet(10, "R6 after setup6");

    conv_data = 24'h777777;
    send_bits(8'hB0);
    send_bits(8'hD8);
    chk(sel_chan == 3'd4, "R11 pointer kept", sel_chan, 4);
    wait_ready(n);
    read_frame(8'h00, w, fb);
    chk(w == frame_word(24'h777777, 3'd6), "R11 frame", w, frame_word(24'h777777, 3'd6));
    quiet(60, "R11 mode kept single");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule